// File: doc/BRIEF.md
# SRAM Bank Power Sequencer

This block holds the bank-enable and block-retention settings of a banked on-chip SRAM and carries them to the bank power controls. Software writes four enable words and four retention words over a simple register bus. Each word carries `REG_W` bits, so there are `4*REG_W` banks. Bank `k` is controlled by bit `k % REG_W` of word `k / REG_W`. The applied settings leave the block on `bank_en_o` and `blk_ret_o`.

When software changes a bit, the matching ready flag drops at once. A sequencer then walks the applied pattern towards the new target. It changes one bank per step and waits a settle delay between steps. The ready flag rises again once the target has been reached. The enable channel and the retention channel each have their own sequencer and their own flag. While the enable flag is low, SRAM access requests get no grant. While the retention flag is low, the low-power controller sees retention-ready low and its deep-sleep request is not granted. After reset, both channels run a first pass from the reset values of the control words.

Top module: `sram_pwr_seq`

## Requirements
- R1: While reset is held, the status word reads 0 and both applied patterns are all-zero. After reset is released, the sequencers apply `EN_RST` and `RET_RST`, and then both ready bits become 1.
- R2: Register map by word address. Addresses 0 to 3 are enable words 0 to 3. Addresses 4 to 7 are retention words 0 to 3. Address 8 is status, with bit 0 = enable-ready and bit 1 = retention-ready. A control word reads its stored value in bits `REG_W-1:0` and zero above that. Status bits 31 to 2 and every other address read 0.
- R3: A write to the status address changes neither the status nor any setting.
- R4: A write that changes any bit of an enable word clears enable-ready in the same clock edge that stores the word.
- R5: A write that changes any bit of a retention word clears retention-ready in the same clock edge that stores the word.
- R6: A write that stores a value equal to the current word leaves both ready bits unchanged.
- R7: Each sequencer changes at most one applied bit per clock. It always picks the lowest-numbered bit where the applied pattern differs from the target. After each change it holds the pattern for `SETTLE` cycles.
- R8: A ready bit becomes 1 at the first clock edge where the applied pattern equals the target, the settle wait is over, and no changing write arrives. While the ready bit is 1, the applied pattern equals the stored words.
- R9: A change that arrives while a sequence is running is folded in. The next step goes to the lowest differing bank, even if that bank lies below the banks still pending.
- R10: `sram_gnt_o` is `sram_req_i` AND enable-ready, so a request is held off, not dropped, until enable-ready is 1.
- R11: `ret_rdy_o` equals retention-ready, and `lp_deep_gnt_o` is `lp_deep_req_i` AND retention-ready.
- R12: The two channels are independent. A change to one channel's words never clears the other channel's ready bit or moves its applied pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i` (combinational) |
| bank_en_o | output | 4*REG_W | Applied bank-enable pattern |
| blk_ret_o | output | 4*REG_W | Applied block-retention pattern |
| sram_req_i | input | 1 | SRAM read or write request |
| sram_gnt_o | output | 1 | SRAM request grant, low while enable settings are changing |
| ret_rdy_o | output | 1 | Retention-ready to the low-power controller |
| lp_deep_req_i | input | 1 | Deep low-power entry request |
| lp_deep_gnt_o | output | 1 | Deep low-power entry grant |

## Verification
The bench targets these corner cases:
- A write of an unchanged value. A design that cleared the flag on every write would stall SRAM traffic for no reason.
- A write to the read-only status word, which a careless decoder would store into a control word.
- A change to a lower enable bank while a higher one is still being stepped. A design that finished its old scan first would apply the banks out of order, and a behavioural reference that picks the lowest differing bank every step exposes this cycle by cycle.
- A retention change while enable is steady. A design that shared one flag or one sequencer would drop SRAM grants during a retention change.

// File: rtl/sps_pkg.sv
package sps_pkg;
    localparam int unsigned NWORD     = 4;
    localparam int unsigned GRP_EN    = 0;
    localparam int unsigned GRP_RET   = 1;
    localparam int unsigned GRP_STAT  = 2;
    localparam int unsigned BIT_EN_OK = 0;
    localparam int unsigned BIT_RT_OK = 1;
    localparam int unsigned CH_EN     = 0;
    localparam int unsigned CH_RET    = 1;
endpackage

// File: rtl/sps_regs.sv
module sps_regs
    import sps_pkg::*;
#(
    parameter int unsigned REG_W  = 8,
    parameter int unsigned ADDR_W = 4,
    parameter logic [NWORD*REG_W-1:0] EN_RST  = '0,
    parameter logic [NWORD*REG_W-1:0] RET_RST = '0
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [REG_W-1:0]         wdata_i,
    output logic [NWORD*REG_W-1:0]   en_tgt_o,
    output logic [NWORD*REG_W-1:0]   ret_tgt_o,
    output logic                     en_chg_o,
    output logic                     ret_chg_o
);
    localparam int unsigned GW = ADDR_W - 2;

    typedef struct packed {
        logic [NWORD-1:0][REG_W-1:0] en;
        logic [NWORD-1:0][REG_W-1:0] ret;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  en_chg_d, ret_chg_d;

    logic [GW-1:0] grp;
    logic [1:0]    idx;
    assign grp = addr_i[ADDR_W-1:2];
    assign idx = addr_i[1:0];

    always_comb begin
        regs_d    = regs_q;
        en_chg_d  = 1'b0;
        ret_chg_d = 1'b0;
        if (wr_i) begin
            if (grp == GW'(GRP_EN) && regs_q.en[idx] != wdata_i) begin
                regs_d.en[idx] = wdata_i;
                en_chg_d       = 1'b1;
            end
            if (grp == GW'(GRP_RET) && regs_q.ret[idx] != wdata_i) begin
                regs_d.ret[idx] = wdata_i;
                ret_chg_d       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.en  <= EN_RST;
            regs_q.ret <= RET_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign en_tgt_o  = regs_q.en;
    assign ret_tgt_o = regs_q.ret;
    assign en_chg_o  = en_chg_d;
    assign ret_chg_o = ret_chg_d;

    // R3: without a write strobe no control word moves
    a_r3_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> ($stable(en_tgt_o) && $stable(ret_tgt_o)));

    // R6: a write whose data equals the stored word flags no change
    a_r6_equal_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && grp == GW'(GRP_EN) && wdata_i == en_tgt_o[idx*REG_W +: REG_W]) |-> !en_chg_o);
endmodule

// File: rtl/sps_chan.sv
module sps_chan #(
    parameter int unsigned NB     = 32,
    parameter int unsigned SETTLE = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [NB-1:0] tgt_i,
    input  logic          chg_i,
    output logic [NB-1:0] applied_o,
    output logic          rdy_o
);
    localparam int unsigned CW = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);

    typedef struct packed {
        logic [NB-1:0] app;
        logic [CW-1:0] wait_cnt;
        logic          rdy;
    } seq_t;

    seq_t s_d, s_q;
    logic [NB-1:0] diff, lowest;

    always_comb begin
        s_d    = s_q;
        diff   = s_q.app ^ tgt_i;
        lowest = diff & (~diff + NB'(1));
        if (s_q.wait_cnt != '0) begin
            s_d.wait_cnt = s_q.wait_cnt - CW'(1);
        end else if (diff != '0) begin
            s_d.app      = s_q.app ^ lowest;
            s_d.wait_cnt = CW'(SETTLE);
        end
        s_d.rdy = !chg_i && (s_q.wait_cnt == '0) && (diff == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign applied_o = s_q.app;
    assign rdy_o     = s_q.rdy;

    // R7: at most one applied bit moves per clock
    a_r7_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(applied_o ^ $past(applied_o)) <= 1);

    // R7: a step is followed by a settle cycle
    a_r7_settle_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (applied_o != $past(applied_o)) |=> $stable(applied_o));

    // R8: ready only with the target fully applied
    a_r8_ready_means_applied: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdy_o |-> (applied_o == tgt_i));
endmodule

// File: rtl/sram_pwr_seq.sv
module sram_pwr_seq
    import sps_pkg::*;
#(
    parameter int unsigned REG_W  = 8,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SETTLE = 3,
    parameter logic [NWORD*REG_W-1:0] EN_RST  = 'h0000_00FF,
    parameter logic [NWORD*REG_W-1:0] RET_RST = 'h0000_000F
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   bus_wr_i,
    input  logic [ADDR_W-1:0]      bus_addr_i,
    input  logic [DATA_W-1:0]      bus_wdata_i,
    output logic [DATA_W-1:0]      bus_rdata_o,
    output logic [NWORD*REG_W-1:0] bank_en_o,
    output logic [NWORD*REG_W-1:0] blk_ret_o,
    input  logic                   sram_req_i,
    output logic                   sram_gnt_o,
    output logic                   ret_rdy_o,
    input  logic                   lp_deep_req_i,
    output logic                   lp_deep_gnt_o
);
    localparam int unsigned NB = NWORD * REG_W;
    localparam int unsigned GW = ADDR_W - 2;

    logic [NB-1:0] tgt [2];
    logic [NB-1:0] app [2];
    logic          chg [2];
    logic          rdy [2];
    logic          unused_wdata;

    assign unused_wdata = ^bus_wdata_i[DATA_W-1:REG_W];

    sps_regs #(
        .REG_W (REG_W),
        .ADDR_W(ADDR_W),
        .EN_RST(EN_RST),
        .RET_RST(RET_RST)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i[REG_W-1:0]),
        .en_tgt_o (tgt[CH_EN]),
        .ret_tgt_o(tgt[CH_RET]),
        .en_chg_o (chg[CH_EN]),
        .ret_chg_o(chg[CH_RET])
    );

    for (genvar c = 0; c < 2; c++) begin : g_chan
        sps_chan #(
            .NB    (NB),
            .SETTLE(SETTLE)
        ) u_chan (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .tgt_i    (tgt[c]),
            .chg_i    (chg[c]),
            .applied_o(app[c]),
            .rdy_o    (rdy[c])
        );
    end

    logic [GW-1:0] grp;
    logic [1:0]    idx;
    assign grp = bus_addr_i[ADDR_W-1:2];
    assign idx = bus_addr_i[1:0];

    always_comb begin
        bus_rdata_o = '0;
        if (grp == GW'(GRP_EN)) begin
            bus_rdata_o[REG_W-1:0] = tgt[CH_EN][idx*REG_W +: REG_W];
        end else if (grp == GW'(GRP_RET)) begin
            bus_rdata_o[REG_W-1:0] = tgt[CH_RET][idx*REG_W +: REG_W];
        end else if (grp == GW'(GRP_STAT) && idx == 2'd0) begin
            bus_rdata_o[BIT_EN_OK] = rdy[CH_EN];
            bus_rdata_o[BIT_RT_OK] = rdy[CH_RET];
        end
    end

    assign bank_en_o     = app[CH_EN];
    assign blk_ret_o     = app[CH_RET];
    assign sram_gnt_o    = sram_req_i & rdy[CH_EN];
    assign ret_rdy_o     = rdy[CH_RET];
    assign lp_deep_gnt_o = lp_deep_req_i & rdy[CH_RET];

    // R4: a changing enable write drops enable-ready at the storing edge
    a_r4_en_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chg[CH_EN] |=> !rdy[CH_EN]);

    // R5: a changing retention write drops retention-ready at the storing edge
    a_r5_ret_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chg[CH_RET] |=> !ret_rdy_o);

    // R12: retention activity leaves a settled enable channel alone
    a_r12_channels_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chg[CH_RET] && !chg[CH_EN] && rdy[CH_EN]) |=> (rdy[CH_EN] && $stable(bank_en_o)));
endmodule

// File: tb/sram_pwr_seq_bench.sv
`timescale 1ns/100ps
module sram_pwr_seq_bench;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned SETTLE = 3;
    localparam int unsigned NB     = 4 * REG_W;
    localparam logic [NB-1:0] EN_RST  = 32'h0000_00FF;
    localparam logic [NB-1:0] RET_RST = 32'h0000_000F;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [NB-1:0]     bank_en, blk_ret;
    logic              sreq = 1'b0, sgnt, rrdy, lreq = 1'b0, lgnt;

    always #2.5 clk = ~clk;

    sram_pwr_seq #(
        .REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE(SETTLE),
        .EN_RST(EN_RST), .RET_RST(RET_RST)
    ) u_sram_pwr_seq (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bank_en_o(bank_en),
        .blk_ret_o(blk_ret), .sram_req_i(sreq), .sram_gnt_o(sgnt),
        .ret_rdy_o(rrdy), .lp_deep_req_i(lreq), .lp_deep_gnt_o(lgnt)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit started = 0;
    int cycles = 0;

    task automatic chk(input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [NB-1:0] m_t [2];
    logic [NB-1:0] m_a [2];
    int            m_c [2];
    bit            m_r [2];

    initial begin
        m_t[0] = EN_RST; m_t[1] = RET_RST;
        m_a[0] = '0; m_a[1] = '0; m_c[0] = 0; m_c[1] = 0; m_r[0] = 0; m_r[1] = 0;
    end

    always @(posedge clk) begin
        logic [NB-1:0] nt [2];
        bit ch [2];
        if (!rst_n) begin
            m_t[0] = EN_RST; m_t[1] = RET_RST;
            for (int c = 0; c < 2; c++) begin
                m_a[c] = '0; m_c[c] = 0; m_r[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                nt[c] = m_t[c];
                ch[c] = 0;
                if (wr && (int'(addr) / 4) == c &&
                    m_t[c][(int'(addr) % 4)*REG_W +: REG_W] != wdata[REG_W-1:0]) begin
                    nt[c][(int'(addr) % 4)*REG_W +: REG_W] = wdata[REG_W-1:0];
                    ch[c] = 1;
                end
            end
            for (int c = 0; c < 2; c++) begin
                bit settled;
                settled = (m_c[c] == 0) && (m_a[c] == m_t[c]);
                if (m_c[c] > 0) begin
                    m_c[c]--;
                end else if (m_a[c] != m_t[c]) begin
                    for (int i = 0; i < NB; i++) begin
                        if (m_a[c][i] != m_t[c][i]) begin
                            m_a[c][i] = m_t[c][i];
                            m_c[c] = SETTLE;
                            break;
                        end
                    end
                end
                m_r[c] = settled && !ch[c];
                m_t[c] = nt[c];
            end
        end
    end

    function automatic logic [DATA_W-1:0] m_read(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] v;
        v = '0;
        if (int'(a) < 4)       v[REG_W-1:0] = m_t[0][int'(a)*REG_W +: REG_W];
        else if (int'(a) < 8)  v[REG_W-1:0] = m_t[1][(int'(a)-4)*REG_W +: REG_W];
        else if (int'(a) == 8) v[1:0] = {m_r[1], m_r[0]};
        return v;
    endfunction

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk("R7", "bank_en_o", bank_en, m_a[0]);
            chk("R7", "blk_ret_o", blk_ret, m_a[1]);
            chk("R2", "bus_rdata_o", rdata, m_read(addr));
            chk("R10", "sram_gnt_o", {31'd0, sgnt}, {31'd0, sreq & m_r[0]});
            chk("R11", "ret_rdy_o", {31'd0, rrdy}, {31'd0, m_r[1]});
            chk("R11", "lp_deep_gnt_o", {31'd0, lgnt}, {31'd0, lreq & m_r[1]});
        end
    end

    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        step(); wr = 1'b1; addr = a; wdata = d;
        step(); wr = 1'b0; addr = 4'd8; wdata = '0;
        #1;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 1000; i++) begin
            if (rdata[1:0] == 2'b11) break;
            step(); addr = 4'd8; #1;
        end
    endtask

    initial begin
        addr = 4'd8;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "status in reset", rdata, 32'd0);
        chk("R1", "bank_en in reset", bank_en, 32'd0);
        rst_n = 1'b1;
        #1;
        chk("R1", "status after release", rdata, 32'd0);
        wait_ready();
        chk("R1", "status after first pass", rdata, 32'd3);
        chk("R1", "enable pattern", bank_en, EN_RST);
        chk("R1", "retention pattern", blk_ret, RET_RST);

        for (int a = 0; a < 8; a++) begin
            step(); addr = ADDR_W'(a); #1;
            chk("R2", "reset word",
                rdata, {24'd0, (a < 4) ? EN_RST[a*8 +: 8] : RET_RST[(a-4)*8 +: 8]});
        end
        step(); addr = 4'd9; #1;
        chk("R2", "unmapped address", rdata, 32'd0);
        step(); addr = 4'd15; #1;
        chk("R2", "unmapped address", rdata, 32'd0);

        do_wr(4'd8, 32'hFFFF_FFFF);
        chk("R3", "status after write", rdata, 32'd3);
        chk("R3", "enable after status write", bank_en, EN_RST);

        do_wr(4'd4, 32'hFFFF_FF0F);
        chk("R6", "status after equal write", rdata, 32'd3);

        sreq = 1'b1;
        do_wr(4'd1, 32'h0000_000F);
        chk("R4", "status after enable change", rdata, 32'd2);
        chk("R12", "retention ready kept", {31'd0, rrdy}, 32'd1);
        chk("R10", "grant held off", {31'd0, sgnt}, 32'd0);
        wait_ready();
        chk("R8", "enable applied", bank_en, 32'h0000_0FFF);
        chk("R10", "grant after ready", {31'd0, sgnt}, 32'd1);

        do_wr(4'd2, 32'h0000_00FF);
        step(); step();
        do_wr(4'd0, 32'h0000_007F);
        begin
            bit low_first;
            low_first = 0;
            for (int i = 0; i < 1000; i++) begin
                if (!bank_en[7] && !bank_en[23]) low_first = 1;
                if (rdata[0]) break;
                step(); #1;
            end
            chk("R9", "lower bank taken first", {31'd0, low_first}, 32'd1);
        end
        chk("R9", "merged enable pattern", bank_en, 32'h00FF_0F7F);
        sreq = 1'b0;

        lreq = 1'b1;
        do_wr(4'd7, 32'h0000_0001);
        chk("R5", "status after retention change", rdata, 32'd1);
        chk("R11", "deep grant held", {31'd0, lgnt}, 32'd0);
        chk("R12", "enable steady", bank_en, 32'h00FF_0F7F);
        wait_ready();
        chk("R11", "deep grant after ready", {31'd0, lgnt}, 32'd1);
        chk("R8", "retention applied", blk_ret, 32'h0100_000F);
        lreq = 1'b0;

        step();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule